// File: doc/BRIEF.md
# Dual-Plane Page-Write Controller for a Multiplexed-Bus Nonvolatile Memory

This block models the write side of a byte-wide nonvolatile memory that sits on a microcontroller bus with shared address and data lines. A pulse on the address strobe captures the low address byte from the shared lines, together with the upper address bits, which arrive on their own pins. A falling edge on the active-low write strobe then loads the byte on the shared lines into a page buffer. Further byte writes to the same page each restart a load window. When the window runs out with no new write, an internal programming cycle of fixed length starts. At its end, the loaded bytes are copied into the storage array.

The most significant address bit selects one of two planes. While a page is loading or programming, a read from the busy plane does not return stored data. It returns a polling byte whose toggle bit inverts on each such read. A read from the other plane returns true stored data, so code can run from one plane while the other is rewritten. Both the window and the programming time are counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the array holds all zeros, `dataOe` is low, and a read of any address returns 0x00.
- R2: A clock edge with `ale` high latches `adIn` as address bits 7..0 and `addrHi` as the upper bits. The next read or write uses that address, even though `adIn` carries data afterwards.
- R3: One page holds up to PAGE_BYTES bytes, selected by address bits 4..0. Only the bytes that were loaded are written to the array. The other bytes of that page keep their old contents.
- R4: Every accepted write restarts a load window of LOAD_CYCLES clocks. A write that arrives inside the window joins the current page. Programming starts only when the window expires with no new write.
- R5: While a page is loading, a write whose address bits above bit 4 differ from those of the page is ignored. It is not stored anywhere and does not restart the window.
- R6: Writes that arrive during the programming cycle are ignored.
- R7: While busy, a read whose top address bit equals the top bit of the page being written returns a polling byte. In that byte, bit TOGGLE_BIT (default 6) inverts on each such read, and all other bits are zero.
- R8: While busy, a read from the other plane returns the true stored data.
- R9: Programming lasts PROG_CYCLES clocks. After that, reads return the new data and a new write opens a new page.
- R10: If the same byte location is written twice within one page load, the value written last is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe, active high |
| adIn | input | 8 | Shared address/data lines as driven by the host |
| addrHi | input | ADDR_W-8 | Upper address bits; the top bit selects the plane |
| wrN | input | 1 | Write strobe, active low; the falling edge loads a byte |
| rdN | input | 1 | Read strobe, active low; the falling edge starts a read |
| dataOut | output | 8 | Read data or polling byte |
| dataOe | output | 1 | High while the block drives the shared lines for a read |

## Verification
A wrong page tag or a wrong load mask does not show at the pins until programming ends, after LOAD_CYCLES plus PROG_CYCLES. It then appears as a wrong byte, or as a changed neighbour byte, when the page is read back. A window timer that does not restart shows up only on a later write within the same page: that write would fall into programming and be lost. Errors in plane selection or in the polling logic show at once, on the first read during a busy period, as a data byte where a polling byte is expected, or the reverse.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef enum logic [1:0] {PG_IDLE, PG_LOAD, PG_PROG} pgState_t;

  typedef struct packed {
    logic openPage;
    logic loadByte;
    logic commitPage;
    logic readNow;
    logic busy;
  } pgCtl_t;
endpackage

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int LOAD_CYCLES = 20000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrN,
  input  logic   rdN,
  input  logic   pageMatch,
  output pgCtl_t ctl,
  output logic   dataOe
);
  localparam int MAX_CNT = (LOAD_CYCLES > PROG_CYCLES) ? LOAD_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  pgState_t   state;
  logic [CNT_W-1:0] cnt;
  logic       wrPrev, rdPrev;
  logic       wrFall, rdFall;

  assign wrFall = wrPrev & ~wrN;
  assign rdFall = rdPrev & ~rdN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      rdPrev <= 1'b1;
      dataOe <= 1'b0;
    end else begin
      wrPrev <= wrN;
      rdPrev <= rdN;
      dataOe <= ~rdN;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.busy    = (state != PG_IDLE);
    ctl.readNow = rdFall;
    case (state)
      PG_IDLE: if (wrFall) begin
        ctl.openPage = 1'b1;
        ctl.loadByte = 1'b1;
      end
      PG_LOAD: if (wrFall && pageMatch) ctl.loadByte = 1'b1;
      PG_PROG: if (cnt == CNT_W'(1)) ctl.commitPage = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PG_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PG_IDLE: if (ctl.openPage) begin
          state <= PG_LOAD;
          cnt   <= CNT_W'(LOAD_CYCLES);
        end
        PG_LOAD: begin
          if (ctl.loadByte) begin
            cnt <= CNT_W'(LOAD_CYCLES);
          end else if (cnt <= CNT_W'(1)) begin
            state <= PG_PROG;
            cnt   <= CNT_W'(PROG_CYCLES);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PG_PROG: begin
          if (ctl.commitPage) begin
            state <= PG_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

  // R6: no byte enters the buffer while the page is programming
  assert_prog_blocks_writes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PG_PROG) |-> (!ctl.loadByte && !ctl.openPage));

  // R4: the window stays open while the countdown has not reached its end
  assert_window_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PG_LOAD && cnt > CNT_W'(1)) |=> (state == PG_LOAD));

  // R4: an accepted byte restarts the countdown
  assert_window_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PG_LOAD && ctl.loadByte) |=> (cnt == CNT_W'(LOAD_CYCLES)));

  // R9: the commit ends the busy period
  assert_commit_ends_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitPage |=> (state == PG_IDLE));
endmodule

// File: rtl/eeprom_page_datapath.sv
module eeprom_page_datapath
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int BUS_W      = 8,
  parameter int PAGE_BYTES = 32,
  parameter int TOGGLE_BIT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ale,
  input  logic [BUS_W-1:0]    adIn,
  input  logic [ADDR_W-BUS_W-1:0] addrHi,
  input  pgCtl_t              ctl,
  output logic                pageMatch,
  output logic [BUS_W-1:0]    dataOut
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] latchAddr;
  logic [TAG_W-1:0]  tagQ;
  logic [PAGE_BYTES-1:0] validQ;
  logic [BUS_W-1:0]  pageBuf [PAGE_BYTES];
  logic [BUS_W-1:0]  mem [DEPTH];
  logic              toggleQ;
  logic [OFF_W-1:0]  offset;
  logic              pollHit;
  logic [BUS_W-1:0]  pollByte;

  assign offset    = latchAddr[OFF_W-1:0];
  assign pageMatch = (latchAddr[ADDR_W-1:OFF_W] == tagQ);
  assign pollHit   = ctl.busy && (latchAddr[ADDR_W-1] == tagQ[TAG_W-1]);

  always_comb begin
    pollByte = '0;
    pollByte[TOGGLE_BIT] = toggleQ;
  end

  // address latch on the multiplexed lines
  always_ff @(posedge clk) begin
    if (!rstN) latchAddr <= '0;
    else if (ale) latchAddr <= {addrHi, adIn};
  end

  // page buffer and load mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ   <= '0;
      validQ <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (ctl.loadByte) begin
      pageBuf[offset] <= adIn;
      if (ctl.openPage) begin
        tagQ   <= latchAddr[ADDR_W-1:OFF_W];
        validQ <= PAGE_BYTES'(1) << offset;
      end else begin
        validQ <= validQ | (PAGE_BYTES'(1) << offset);
      end
    end
  end

  // storage array: only masked bytes are committed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (ctl.commitPage) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (validQ[i]) mem[{tagQ, OFF_W'(i)}] <= pageBuf[i];
    end
  end

  // read path with toggle polling on the busy plane
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      toggleQ <= 1'b0;
    end else if (ctl.readNow) begin
      if (pollHit) begin
        dataOut <= pollByte;
        toggleQ <= ~toggleQ;
      end else begin
        dataOut <= mem[latchAddr];
      end
    end
  end

  // R5: a byte joins an open page only when its upper bits match the page
  assert_tag_match_on_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadByte && !ctl.openPage) |-> pageMatch);

  // R3: opening a page leaves exactly one location marked
  assert_fresh_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.openPage |=> ($countones(validQ) == 1));

  // R7: every polling read flips the toggle bit
  assert_poll_flip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readNow && pollHit) |=> (toggleQ != $past(toggleQ)));

  // R8: reads outside the busy plane never disturb the toggle state
  assert_other_plane_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readNow && !pollHit) |=> $stable(toggleQ));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int TOGGLE_BIT  = 6,
  parameter int LOAD_CYCLES = 20000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [7:0]        adIn,
  input  logic [ADDR_W-9:0] addrHi,
  input  logic              wrN,
  input  logic              rdN,
  output logic [7:0]        dataOut,
  output logic              dataOe
);
  pgCtl_t ctl;
  logic   pageMatch;

  eeprom_page_ctrl #(
    .LOAD_CYCLES(LOAD_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN),
    .pageMatch(pageMatch), .ctl(ctl), .dataOe(dataOe)
  );

  eeprom_page_datapath #(
    .ADDR_W(ADDR_W), .BUS_W(8),
    .PAGE_BYTES(PAGE_BYTES), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .ale(ale), .adIn(adIn), .addrHi(addrHi),
    .ctl(ctl), .pageMatch(pageMatch), .dataOut(dataOut)
  );
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int LOAD = 24;
  localparam int PROG = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ale = 1'b0;
  logic [7:0] adIn = '0;
  logic [2:0] addrHi = '0;
  logic wrN = 1'b1;
  logic rdN = 1'b1;
  logic [7:0] dataOut;
  logic dataOe;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(11), .PAGE_BYTES(32), .TOGGLE_BIT(6),
    .LOAD_CYCLES(LOAD), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ale(ale), .adIn(adIn), .addrHi(addrHi),
    .wrN(wrN), .rdN(rdN), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [10:0] addr, input logic [7:0] val);
    @(negedge clk);
    ale = 1'b1; adIn = addr[7:0]; addrHi = addr[10:8];
    @(posedge clk);
    @(negedge clk);
    ale = 1'b0; adIn = val; wrN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wrN = 1'b1;
    @(posedge clk);
  endtask

  task automatic readByte(input logic [10:0] addr, output logic [7:0] val, output logic oe);
    @(negedge clk);
    ale = 1'b1; adIn = addr[7:0]; addrHi = addr[10:8];
    @(posedge clk);
    @(negedge clk);
    ale = 1'b0; adIn = 8'hEE; rdN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    val = dataOut; oe = dataOe;
    rdN = 1'b1;
    @(posedge clk);
  endtask

  task automatic expectRead(input string req, input logic [10:0] addr, input logic [7:0] exp);
    logic [7:0] v; logic oe;
    readByte(addr, v, oe);
    check(req, v, exp);
  endtask

  // two same-plane reads while busy: only bit 6 differs, other bits zero
  task automatic expectPoll(input string req, input logic [10:0] addr);
    logic [7:0] a, b; logic oe;
    readByte(addr, a, oe);
    readByte(addr, b, oe);
    check(req, a & 8'hBF, 8'h00);
    check(req, a ^ b, 8'h40);
  endtask

  task automatic waitDone();
    repeat (LOAD + PROG + 8) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 oe", {7'b0, dataOe}, 8'h00);
    expectRead("R1", 11'h000, 8'h00);
    expectRead("R1", 11'h7FF, 8'h00);
  endtask

  task automatic t_page_basic();
    writeByte(11'h020, 8'hA1);
    writeByte(11'h025, 8'hB2);
    writeByte(11'h03F, 8'hC3);
    waitDone();
    expectRead("R2 R9", 11'h020, 8'hA1);
    expectRead("R3", 11'h025, 8'hB2);
    expectRead("R3", 11'h03F, 8'hC3);
    expectRead("R3 untouched", 11'h021, 8'h00);
  endtask

  task automatic t_planes();
    writeByte(11'h440, 8'h5A);
    waitDone();
    writeByte(11'h060, 8'h11);
    expectRead("R8 load", 11'h440, 8'h5A);
    expectPoll("R7 load", 11'h060);
    repeat (LOAD + 5) @(posedge clk);
    expectPoll("R7 prog", 11'h07C);
    expectRead("R8 prog", 11'h440, 8'h5A);
    waitDone();
    expectRead("R9", 11'h060, 8'h11);
  endtask

  task automatic t_restart();
    writeByte(11'h100, 8'h01);
    repeat (LOAD - 8) @(posedge clk);
    writeByte(11'h101, 8'h02);
    repeat (LOAD - 8) @(posedge clk);
    writeByte(11'h102, 8'h03);
    repeat (LOAD - 4) @(posedge clk);
    expectPoll("R4 busy", 11'h100);
    waitDone();
    expectRead("R4", 11'h100, 8'h01);
    expectRead("R4", 11'h101, 8'h02);
    expectRead("R4 restart", 11'h102, 8'h03);
  endtask

  task automatic t_mismatch();
    writeByte(11'h080, 8'h77);
    writeByte(11'h0A3, 8'h88);
    writeByte(11'h081, 8'h99);
    waitDone();
    expectRead("R5 ignored", 11'h0A3, 8'h00);
    expectRead("R5", 11'h080, 8'h77);
    expectRead("R5", 11'h081, 8'h99);
  endtask

  task automatic t_prog_ignore();
    writeByte(11'h0C0, 8'h31);
    repeat (LOAD + 4) @(posedge clk);
    writeByte(11'h0C1, 8'h42);
    writeByte(11'h0C0, 8'h43);
    waitDone();
    expectRead("R6", 11'h0C0, 8'h31);
    expectRead("R6", 11'h0C1, 8'h00);
    writeByte(11'h0C1, 8'h44);
    waitDone();
    expectRead("R9 next", 11'h0C1, 8'h44);
  endtask

  task automatic t_overwrite();
    writeByte(11'h0E2, 8'h01);
    writeByte(11'h0E2, 8'h02);
    waitDone();
    expectRead("R10", 11'h0E2, 8'h02);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_page_basic();
    t_planes();
    t_restart();
    t_mismatch();
    t_prog_ignore();
    t_overwrite();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule